// File: doc/BRIEF.md
# Key-Guarded Watchdog Register Interface

This block is the bus-facing register file of a small watchdog timer. It keeps three registers: an 8-bit up-counter, an 8-bit control byte, and a reset-status register. The reset-status register holds an overflow flag, a reset-enable bit and a reset-select bit. Writes are accepted only as full 16-bit words. Byte writes are dropped. The upper byte of every write word is a key that decides whether the write takes effect and where it goes.

Offset 0 is one write address shared by the counter and the control byte. The key picks which of the two receives the lower byte. Offset 2 reaches the reset-status register. At that offset one key clears the overflow flag, and the other key loads the enable and select bits. Reads are byte-wide and combinational.

The counter advances on a tick strobe while the run bit of the control byte is set. A wrap from 0xFF to 0x00 sets the overflow flag. If reset-enable is on at that moment, a level reset request is also raised.

Top module: `wdg_keyreg`

## Requirements
- R1: A write with `wr_word` low (byte-sized) changes no register at any offset.
- R2: A word write at offset 0 with upper byte 0x5A loads the lower byte into the counter. The new value is readable from the cycle after the write edge.
- R3: A word write at offset 0 with upper byte 0xA5 loads the lower byte into the control byte.
- R4: The word 0xA500 written at offset 2 clears the overflow flag and the reset request. Reset-enable and reset-select are left unchanged.
- R5: A word write at offset 2 with upper byte 0x5A copies lower-byte bit 6 into reset-enable and bit 5 into reset-select. The overflow flag is left unchanged.
- R6: The following writes have no effect on any register: a word write at offset 0 or 2 whose key is neither 0x5A nor 0xA5; a write of upper byte 0xA5 with a nonzero lower byte at offset 2; any write at offset 1 or 3.
- R7: On a tick, the counter increments by one when control-byte bit 5 (run) is 1. With run at 0 the counter holds.
- R8: An increment from 0xFF to 0x00 sets the overflow flag. If reset-enable was 1 it also raises `rst_req`. `rst_req` then stays high until an R4 clear or reset.
- R9: When a key-accepted counter write and a tick arrive in the same cycle, the written value wins and no overflow is recorded.
- R10: When an overflow and an R4 clear arrive in the same cycle, the flag ends up set.
- R11: Read data by `rd_addr`:
  - 0: the control byte.
  - 1: the counter.
  - 2: {overflow, reset-enable, reset-select, 5'b11111}.
  - 3: 0xFF.
- R12: Synchronous reset sets the counter, the control byte, all three flag bits and `rst_req` to 0. Offset 2 therefore reads 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 1 | 1 = 16-bit word write, 0 = byte write |
| wr_addr | input | 2 | Write offset |
| wr_data | input | 16 | Write word: key in [15:8], data in [7:0] |
| rd_addr | input | 2 | Read offset |
| rd_data | output | 8 | Read byte |
| tick | input | 1 | Counter advance strobe |
| rst_req | output | 1 | Reset request level |

## Verification
Every register is visible through the read port. A wrong counter, control bit or flag bit therefore appears in `rd_data` in the first cycle after the faulty edge, and the bench reads all four offsets in every cycle. A wrong reset-request level shows directly on `rst_req` in the same cycle. Key misdecoding shows up as a register that changes when it should hold, or holds when it should load. Priority faults show up in the single cycle where a tick collides with a write.

// File: rtl/wdg_keyreg_pkg.sv
package wdg_keyreg_pkg;

    localparam int BUS_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int FLAG_W  = 3;
    localparam int PAD_W   = BYTE_W - FLAG_W;

    localparam logic [BYTE_W-1:0] KEY_LO = 8'h5A;
    localparam logic [BYTE_W-1:0] KEY_HI = 8'hA5;

    localparam logic [ADDR_W-1:0] OFS_SHARED = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_FLAGS  = 2'd2;

    localparam int FLAG_EN_BIT  = 6;
    localparam int FLAG_SEL_BIT = 5;

    typedef struct packed {
        logic                load_cnt;
        logic                load_ctl;
        logic                clr_flag;
        logic                cfg_flag;
        logic [BYTE_W-1:0]   data;
    } wr_cmd_t;

    typedef struct packed {
        logic ovf;
        logic en;
        logic sel;
    } flag_t;

    function automatic logic key_is(input logic [BUS_W-1:0] w, input logic [BYTE_W-1:0] k);
        return w[BUS_W-1:BYTE_W] == k;
    endfunction

    function automatic logic [BYTE_W-1:0] flag_byte(input flag_t f);
        return {f.ovf, f.en, f.sel, {PAD_W{1'b1}}};
    endfunction

endpackage

// File: rtl/wdg_wr_decode.sv
module wdg_wr_decode
    import wdg_keyreg_pkg::*;
(
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output wr_cmd_t           cmd
);
    logic word_ok;
    logic hit_shared;
    logic hit_flags;
    logic lo_zero;

    assign word_ok    = wr_en && wr_word;
    assign hit_shared = word_ok && (wr_addr == OFS_SHARED);
    assign hit_flags  = word_ok && (wr_addr == OFS_FLAGS);
    assign lo_zero    = (wr_data[BYTE_W-1:0] == '0);

    always_comb begin
        cmd          = '0;
        cmd.data     = wr_data[BYTE_W-1:0];
        cmd.load_cnt = hit_shared && key_is(wr_data, KEY_LO);
        cmd.load_ctl = hit_shared && key_is(wr_data, KEY_HI);
        cmd.clr_flag = hit_flags  && key_is(wr_data, KEY_HI) && lo_zero;
        cmd.cfg_flag = hit_flags  && key_is(wr_data, KEY_LO);
    end
endmodule

// File: rtl/wdg_tick_counter.sv
module wdg_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic step;

    assign step = tick && run && !load;
    assign wrap = step && (count == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/wdg_flag_reg.sv
module wdg_flag_reg
    import wdg_keyreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wrap,
    input  logic  clr,
    input  logic  cfg,
    input  logic  cfg_en,
    input  logic  cfg_sel,
    output flag_t flags,
    output logic  req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            req   <= 1'b0;
        end else begin
            if (wrap) begin
                flags.ovf <= 1'b1;
                if (flags.en) begin
                    req <= 1'b1;
                end
            end else if (clr) begin
                flags.ovf <= 1'b0;
                req       <= 1'b0;
            end
            if (cfg) begin
                flags.en  <= cfg_en;
                flags.sel <= cfg_sel;
            end
        end
    end
endmodule

// File: rtl/wdg_keyreg.sv
module wdg_keyreg
    import wdg_keyreg_pkg::*;
#(
    parameter int RUN_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              tick,
    output logic              rst_req
);
    wr_cmd_t           cmd;
    logic [BYTE_W-1:0] cnt_q;
    logic [BYTE_W-1:0] ctl_q;
    logic              cnt_wrap;
    flag_t             flags;

    wdg_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (cmd.load_ctl) begin
            ctl_q <= cmd.data;
        end
    end

    wdg_tick_counter #(.W(BYTE_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .run      (ctl_q[RUN_BIT]),
        .load     (cmd.load_cnt),
        .load_val (cmd.data),
        .count    (cnt_q),
        .wrap     (cnt_wrap)
    );

    wdg_flag_reg u_flg (
        .clk     (clk),
        .rst     (rst),
        .wrap    (cnt_wrap),
        .clr     (cmd.clr_flag),
        .cfg     (cmd.cfg_flag),
        .cfg_en  (cmd.data[FLAG_EN_BIT]),
        .cfg_sel (cmd.data[FLAG_SEL_BIT]),
        .flags   (flags),
        .req     (rst_req)
    );

    always_comb begin
        unique case (rd_addr)
            OFS_SHARED: rd_data = ctl_q;
            OFS_COUNT:  rd_data = cnt_q;
            OFS_FLAGS:  rd_data = flag_byte(flags);
            default:    rd_data = '1;
        endcase
    end
endmodule

// File: rtl/wdg_keyreg_chk.sv
module wdg_keyreg_chk
    import wdg_keyreg_pkg::*;
#(
    parameter int RUN_BIT = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_word,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BUS_W-1:0]  wr_data,
    input logic              tick,
    input logic [BYTE_W-1:0] cnt_q,
    input logic [BYTE_W-1:0] ctl_q,
    input flag_t             flags,
    input logic              rst_req
);
    logic w_shared_lo, w_shared_hi, w_flag_lo, w_flag_clr, overflow_now;

    assign w_shared_lo  = wr_en && wr_word && wr_addr == OFS_SHARED && wr_data[15:8] == KEY_LO;
    assign w_shared_hi  = wr_en && wr_word && wr_addr == OFS_SHARED && wr_data[15:8] == KEY_HI;
    assign w_flag_lo    = wr_en && wr_word && wr_addr == OFS_FLAGS  && wr_data[15:8] == KEY_LO;
    assign w_flag_clr   = wr_en && wr_word && wr_addr == OFS_FLAGS  && wr_data == 16'hA500;
    assign overflow_now = tick && ctl_q[RUN_BIT] && cnt_q == 8'hFF && !w_shared_lo;

    a_r1_byte_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_word && !tick) |=> ($stable(cnt_q) && $stable(ctl_q) && $stable(flags)));

    a_r2_counter_load: assert property (@(posedge clk) disable iff (rst)
        w_shared_lo |=> (cnt_q == $past(wr_data[7:0])));

    a_r3_control_load: assert property (@(posedge clk) disable iff (rst)
        w_shared_hi |=> (ctl_q == $past(wr_data[7:0])));

    a_r4_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (w_flag_clr && !overflow_now) |=> (!flags.ovf && !rst_req));

    a_r5_flag_config: assert property (@(posedge clk) disable iff (rst)
        w_flag_lo |=> (flags.en == $past(wr_data[6]) && flags.sel == $past(wr_data[5])));

    a_r8_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        overflow_now |=> flags.ovf);

    a_r8_req_needs_flag: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> flags.ovf);

    a_r9_load_beats_tick: assert property (@(posedge clk) disable iff (rst)
        (w_shared_lo && tick && !flags.ovf && !w_flag_clr) |=> !flags.ovf);
endmodule

bind wdg_keyreg wdg_keyreg_chk #(.RUN_BIT(RUN_BIT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .tick    (tick),
    .cnt_q   (cnt_q),
    .ctl_q   (ctl_q),
    .flags   (flags),
    .rst_req (rst_req)
);

// File: tb/wdg_keyreg_tb.sv
`timescale 1ns/100ps
module wdg_keyreg_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_word = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        tick = 1'b0;
    logic        rst_req;

    int n_tests = 0;
    int n_fail  = 0;
    string tag = "R12";

    // reference state
    int m_cnt = 0, m_ctl = 0;
    bit m_ovf = 0, m_en = 0, m_sel = 0, m_req = 0;

    always #4 clk = ~clk;

    wdg_keyreg u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .tick(tick), .rst_req(rst_req)
    );

    always @(posedge clk) begin
        bit word, cnt_w, ctl_w, clr, cfg, wrapped, run;
        int key, lo;
        word = wr_en && wr_word;
        key  = wr_data[15:8];
        lo   = wr_data[7:0];
        run  = (m_ctl / 32) % 2 == 1;
        cnt_w = word && wr_addr == 0 && key == 'h5A;
        ctl_w = word && wr_addr == 0 && key == 'hA5;
        clr   = word && wr_addr == 2 && key == 'hA5 && lo == 0;
        cfg   = word && wr_addr == 2 && key == 'h5A;
        wrapped = 0;
        if (rst) begin
            m_cnt = 0; m_ctl = 0; m_ovf = 0; m_en = 0; m_sel = 0; m_req = 0;
        end else begin
            if (cnt_w) m_cnt = lo;
            else if (tick && run) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == 256) begin m_cnt = 0; wrapped = 1; end
            end
            if (ctl_w) m_ctl = lo;
            if (wrapped) begin
                m_ovf = 1;
                if (m_en) m_req = 1;
            end else if (clr) begin
                m_ovf = 0; m_req = 0;
            end
            if (cfg) begin
                m_en  = (lo / 64) % 2 == 1;
                m_sel = (lo / 32) % 2 == 1;
            end
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int a = 0; a < 4; a++) begin
            logic [7:0] exp;
            rd_addr = a[1:0];
            #0.5;
            case (a)
                0: exp = m_ctl[7:0];
                1: exp = m_cnt[7:0];
                2: exp = {m_ovf, m_en, m_sel, 5'b11111};
                default: exp = 8'hFF;
            endcase
            check(rd_data, exp, $sformatf("rd offset %0d", a));
        end
        check({7'd0, rst_req}, {7'd0, m_req}, "rst_req");
    endtask

    task automatic step(input bit we, input bit wd, input logic [1:0] ad,
                        input logic [15:0] dat, input bit tk);
        wr_en = we; wr_word = wd; wr_addr = ad; wr_data = dat; tick = tk;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 16'h0, 0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        rst = 1'b0;
        tag = "R12"; idle(1);
        tag = "R11"; check(8'h1F, {m_ovf, m_en, m_sel, 5'b11111}, "reset flag read");

        tag = "R1";
        step(1, 0, 0, 16'h5A33, 0);
        step(1, 0, 0, 16'hA5FF, 0);
        step(1, 0, 2, 16'h5A60, 0);
        tag = "R2"; step(1, 1, 0, 16'h5A3C, 0);
        tag = "R3"; step(1, 1, 0, 16'hA5C1, 0);
        tag = "R5"; step(1, 1, 2, 16'h5A60, 0);
        step(1, 1, 2, 16'h5A20, 0);
        tag = "R6";
        step(1, 1, 0, 16'h1277, 0);
        step(1, 1, 2, 16'hA501, 0);
        step(1, 1, 2, 16'hFF00, 0);
        step(1, 1, 1, 16'h5A99, 0);
        step(1, 1, 3, 16'hA500, 0);
        tag = "R7";
        step(1, 1, 0, 16'hA500, 1);
        step(0, 0, 0, 0, 1);
        step(1, 1, 0, 16'hA520, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);

        tag = "R8";
        step(1, 1, 2, 16'h5A40, 0);
        step(1, 1, 0, 16'h5AFE, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        check({7'd0, rst_req}, 8'h01, "request after wrap");
        idle(2);
        tag = "R4"; step(1, 1, 2, 16'hA500, 0);
        check({7'd0, rst_req}, 8'h00, "request after clear");

        tag = "R9";
        step(1, 1, 0, 16'h5AFF, 0);
        step(1, 1, 0, 16'h5A10, 1);
        step(0, 0, 0, 0, 1);

        tag = "R10";
        step(1, 1, 0, 16'h5AFF, 0);
        step(1, 1, 2, 16'hA500, 1);
        step(1, 1, 2, 16'hA500, 0);

        tag = "R12";
        rst = 1'b1; step(0, 0, 0, 0, 1); rst = 1'b0;
        idle(1);

        tag = "R6";
        step(1, 1, 0, 16'hA520, 0);
        for (int i = 0; i < 3000; i++) begin
            int k;
            logic [15:0] d;
            k = $urandom_range(0, 3);
            d[7:0]  = $urandom_range(0, 255);
            d[15:8] = (k == 0) ? 8'h5A : (k == 1) ? 8'hA5 : $urandom_range(0, 255);
            if (k == 1 && $urandom_range(0, 1) == 1) d[7:0] = 8'h00;
            step($urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0,
                 2'($urandom_range(0, 3)), d, $urandom_range(0, 1) == 1);
        end
        finish_run();
    end
endmodule